// File: doc/BRIEF.md
# Immediate Shift, Field Extract and Half-Word Multiply Slice

This block is one execution slice of a 32-bit integer datapath. Each clock it takes an operation select, two 32-bit register operands and three raw immediate fields, just as they sit in the instruction: a 4-bit amount field, a 1-bit amount extension and a 4-bit width field. It registers a 32-bit result and an illegal-operation flag. Instruction decode and register writeback sit outside the block.

The immediates stay in their encoded form up to this slice, and the slice decodes them. The left shift holds "32 minus amount". The logical right shift can only reach 15 bit positions. The extract width is stored as one less than the number of bits kept. Both multiplies use only the low half-word of each operand. Select codes 6 and 7 are reserved.

Top module: `shx_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result_o` and `illegal_o` become zero at that edge.
- R2: Results are registered: the outputs after a rising edge reflect the inputs sampled at that edge, one cycle of latency, with a new operation accepted every cycle.
- R3: Select 0 (left shift) forms a 5-bit code k = {`amt_ext_i`, `amt_lo_i`} and returns `opa_i` shifted left by 32 − k, with zeros filled in.
- R4: Select 0 with code k = 0 means a shift of 32 and returns zero, not the unshifted operand.
- R5: Select 1 (arithmetic right shift) returns `opa_i` shifted right by {`amt_ext_i`, `amt_lo_i`} (0 to 31), filling with copies of bit 31.
- R6: Select 2 (logical right shift) shifts `opa_i` right by `amt_lo_i` alone (0 to 15), with zero fill. `amt_ext_i` has no effect.
- R7: Select 3 (extract) shifts `opa_i` right by {`amt_ext_i`, `amt_lo_i`} and keeps the low `width_i` + 1 bits (1 to 16). All higher bits are zero.
- R8: Select 4 (unsigned multiply) returns the 32-bit product of the zero-extended low 16 bits of `opa_i` and `opb_i`.
- R9: Select 5 (signed multiply) returns the low 32 bits of the product of the sign-extended low 16 bits of `opa_i` and `opb_i`.
- R10: Selects 6 and 7 return a zero result with `illegal_o` high. For selects 0 to 5, `illegal_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation select (0 to 5 valid, 6 and 7 reserved) |
| opa_i | input | 32 | First operand (operand that is shifted or extracted, multiplicand) |
| opb_i | input | 32 | Second operand (multiplier) |
| amt_lo_i | input | 4 | Low four bits of the shift amount code |
| amt_ext_i | input | 1 | Bit 4 of the shift amount code |
| width_i | input | 4 | Extract width minus one |
| result_o | output | 32 | Registered result |
| illegal_o | output | 1 | Registered reserved-select flag |

## Verification
Directed vectors cover every left-shift code from 0 to 31 on an all-ones operand, which separates "32 minus code" from a plain code and shows the code-0 zero case. Arithmetic and logical right shifts run on operands with bit 31 set and with bit 31 clear, with the extension bit both set and clear. This tells sign fill from zero fill and shows that the logical shift ignores the extension bit. Extracts sweep all sixteen widths. Multiplies use half-words at 0x8000, 0xFFFF and zero, with junk in the upper half-words, so signed and unsigned extension give different products. A long run of pseudo-random vectors over all eight selects, driven back to back, then checks the one-cycle pipeline.

// File: rtl/shx_pkg.sv
package shx_pkg;

    localparam int DATA_W  = 32;
    localparam int HALF_W  = DATA_W / 2;
    localparam int FIELD_W = 4;
    localparam int AMT_W   = FIELD_W + 1;
    localparam int OPSEL_W = 3;

    typedef enum logic [OPSEL_W-1:0] {
        OP_SHL  = 3'd0,
        OP_SRA  = 3'd1,
        OP_SRL  = 3'd2,
        OP_EXT  = 3'd3,
        OP_MULU = 3'd4,
        OP_MULS = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    // Decoded immediate bundle carried from the edge into the datapath.
    typedef struct packed {
        logic [AMT_W-1:0]   amt5;   // {ext, lo}
        logic [FIELD_W-1:0] amt4;   // lo only
        logic [FIELD_W-1:0] wsel;   // width minus one
    } imm_t;

    function automatic imm_t decode_imm(input logic [FIELD_W-1:0] lo,
                                        input logic               ext,
                                        input logic [FIELD_W-1:0] w);
        imm_t d;
        d.amt5 = {ext, lo};
        d.amt4 = lo;
        d.wsel = w;
        return d;
    endfunction

    // Mask with the low (w + 1) bits set.
    function automatic logic [DATA_W-1:0] field_mask(input logic [FIELD_W-1:0] w);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < (1 << FIELD_W); i++) begin
            m[i] = (i <= int'(w));
        end
        return m;
    endfunction

    function automatic logic is_legal(input op_e op);
        return (op != OP_RSV6) && (op != OP_RSV7);
    endfunction

endpackage

// File: rtl/shx_shift_unit.sv
module shx_shift_unit
    import shx_pkg::*;
#(
    parameter int DW = shx_pkg::DATA_W
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  imm_t          imm,
    output logic [DW-1:0] res
);
    localparam int LAMT_W = AMT_W + 1;

    logic [LAMT_W-1:0] left_amt;
    logic [DW-1:0]     shl_v;
    logic [DW-1:0]     sra_v;
    logic [DW-1:0]     srl_v;
    logic [DW-1:0]     ext_v;

    // Encoded code k means a shift of 32 - k; k = 0 gives 32 and must clear.
    assign left_amt = LAMT_W'(1 << AMT_W) - LAMT_W'(imm.amt5);
    assign shl_v    = left_amt[AMT_W] ? '0 : (a << left_amt[AMT_W-1:0]);
    assign sra_v    = DW'($signed(a) >>> imm.amt5);
    assign srl_v    = a >> imm.amt4;
    assign ext_v    = (a >> imm.amt5) & field_mask(imm.wsel);

    always_comb begin
        unique case (op)
            OP_SHL:  res = shl_v;
            OP_SRA:  res = sra_v;
            OP_SRL:  res = srl_v;
            OP_EXT:  res = ext_v;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/shx_mul16.sv
module shx_mul16
    import shx_pkg::*;
#(
    parameter int DW = shx_pkg::DATA_W,
    parameter int HW = shx_pkg::HALF_W
) (
    input  logic          signed_mode,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] prod
);
    logic [DW-1:0] xa;
    logic [DW-1:0] xb;

    // Extend to full width first; the low DW bits of the product are then
    // the same for signed and unsigned, so a single multiplier serves both.
    assign xa   = {{(DW-HW){signed_mode & a[HW-1]}}, a[HW-1:0]};
    assign xb   = {{(DW-HW){signed_mode & b[HW-1]}}, b[HW-1:0]};
    assign prod = xa * xb;
endmodule

// File: rtl/shx_alu.sv
module shx_alu
    import shx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [OPSEL_W-1:0]  op_i,
    input  logic [DATA_W-1:0]   opa_i,
    input  logic [DATA_W-1:0]   opb_i,
    input  logic [FIELD_W-1:0]  amt_lo_i,
    input  logic                amt_ext_i,
    input  logic [FIELD_W-1:0]  width_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                illegal_o
);
    op_e               op;
    imm_t              imm;
    logic [DATA_W-1:0] shift_res;
    logic [DATA_W-1:0] mul_res;
    logic [DATA_W-1:0] next_res;
    logic              legal;

    assign op    = op_e'(op_i);
    assign imm   = decode_imm(amt_lo_i, amt_ext_i, width_i);
    assign legal = is_legal(op);

    shx_shift_unit #(.DW(DATA_W)) u_shift (
        .op  (op),
        .a   (opa_i),
        .imm (imm),
        .res (shift_res)
    );

    shx_mul16 #(.DW(DATA_W), .HW(HALF_W)) u_mul (
        .signed_mode (op == OP_MULS),
        .a           (opa_i),
        .b           (opb_i),
        .prod        (mul_res)
    );

    always_comb begin
        unique case (op)
            OP_MULU, OP_MULS:               next_res = mul_res;
            OP_SHL, OP_SRA, OP_SRL, OP_EXT: next_res = shift_res;
            default:                        next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o  <= '0;
            illegal_o <= 1'b0;
        end else begin
            result_o  <= next_res;
            illegal_o <= ~legal;
        end
    end

    AST_ILLEGAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (result_o == '0));                                   // R10

    AST_RESERVED_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (op_i[2:1] == 2'b11) |=> illegal_o);                               // R10

    AST_SHL_FULL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHL && {amt_ext_i, amt_lo_i} == '0) |=> (result_o == '0)); // R4

    AST_EXT_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (op == OP_EXT && width_i == '0) |=> (result_o[DATA_W-1:1] == '0)); // R7

    AST_MUL_ZERO_HALF: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_MULU || op == OP_MULS) && opa_i[HALF_W-1:0] == '0)
            |=> (result_o == '0));                                         // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (result_o == '0 && !illegal_o));                           // R1
endmodule

// File: tb/shx_alu_bench.sv
`timescale 1ns/1ps
module shx_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [3:0]  amt_lo_i = '0;
    logic        amt_ext_i = 1'b0;
    logic [3:0]  width_i = '0;
    logic [31:0] result_o;
    logic        illegal_o;

    int          n_vec = 0;
    int          n_bad = 0;
    bit          pending = 0;
    logic [31:0] exp_res;
    logic        exp_ill;
    string       exp_tag;

    always #4 clk = ~clk;   // 125 MHz

    shx_alu u_shx_alu (
        .clk(clk), .rst(rst), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
        .amt_lo_i(amt_lo_i), .amt_ext_i(amt_ext_i), .width_i(width_i),
        .result_o(result_o), .illegal_o(illegal_o)
    );

    // Behavioural reference model.
    task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                         input int lo, input int ext, input int w,
                         output logic [31:0] r, output logic ill, output string tag);
        int          code = ext * 16 + lo;
        longint      pa, pb;
        longint      p;
        ill = 1'b0;
        case (op)
            0: begin
                r   = (code == 0) ? 32'h0 : (a << (32 - code));
                tag = (code == 0) ? "R4" : "R3";
            end
            1: begin r = 32'($signed(a) >>> code); tag = "R5"; end
            2: begin r = a >> lo; tag = "R6"; end
            3: begin
                r   = (a >> code) & 32'((64'd1 << (w + 1)) - 1);
                tag = "R7";
            end
            4: begin
                p = longint'(a[15:0]) * longint'(b[15:0]);
                r = p[31:0]; tag = "R8";
            end
            5: begin
                pa = longint'($signed(a[15:0]));
                pb = longint'($signed(b[15:0]));
                p  = pa * pb;
                r  = p[31:0]; tag = "R9";
            end
            default: begin r = 32'h0; ill = 1'b1; tag = "R10"; end
        endcase
    endtask

    task automatic compare(input logic [31:0] er, input logic ei, input string tag);
        n_vec++;
        if (result_o !== er || illegal_o !== ei) begin
            n_bad++;
            $display("FAIL %s (R2 pipeline): got res=%h ill=%b expected res=%h ill=%b",
                     tag, result_o, illegal_o, er, ei);
        end
    endtask

    // One clock per call: check the previous vector, then drive the next.
    task automatic step(input int op, input logic [31:0] a, input logic [31:0] b,
                        input int lo, input int ext, input int w);
        @(negedge clk);
        if (pending) compare(exp_res, exp_ill, exp_tag);
        op_i = 3'(op); opa_i = a; opb_i = b;
        amt_lo_i = 4'(lo); amt_ext_i = 1'(ext); width_i = 4'(w);
        model(op, a, b, lo, ext, w, exp_res, exp_ill, exp_tag);
        pending = 1;
    endtask

    initial begin
        #(200000 * 8);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset with a reserved select and live operands present.
        op_i = 3'd7; opa_i = 32'hFFFF_FFFF;
        repeat (3) begin
            @(negedge clk);
            compare(32'h0, 1'b0, "R1");
        end
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < 32; k++) step(0, 32'hFFFF_FFFF, 0, k % 16, k / 16, 0);   // R3 R4
        step(0, 32'h1234_5678, 0, 0, 0, 0);                                          // R4
        for (int k = 0; k < 32; k += 5) begin
            step(1, 32'h8000_1234, 0, k % 16, k / 16, 0);                            // R5
            step(1, 32'h7000_1234, 0, k % 16, k / 16, 0);
        end
        for (int k = 0; k < 16; k++) begin
            step(2, 32'hF00F_000F, 0, k, 0, 0);                                      // R6
            step(2, 32'hF00F_000F, 0, k, 1, 0);                                      // R6 ext ignored
        end
        for (int w = 0; w < 16; w++) step(3, 32'hDEAD_BEEF, 0, w, w & 1, w);        // R7
        step(3, 32'hFFFF_FFFF, 0, 15, 1, 15);
        step(4, 32'hABCD_8000, 32'h1111_FFFF, 0, 0, 0);                              // R8
        step(5, 32'hABCD_8000, 32'h1111_FFFF, 0, 0, 0);                              // R9
        step(5, 32'h0000_8000, 32'h0000_8000, 0, 0, 0);
        step(4, 32'h0000_FFFF, 32'h0000_FFFF, 0, 0, 0);
        step(5, 32'h0000_0000, 32'hFFFF_FFFF, 0, 0, 0);
        step(6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 15, 1, 15);                            // R10
        step(7, 32'h1, 32'h1, 1, 0, 1);
        step(0, 32'h1, 0, 1, 1, 0);                                                  // flag drops
        for (int i = 0; i < 2000; i++)
            step(int'($urandom_range(0, 7)), $urandom, $urandom,
                 int'($urandom_range(0, 15)), int'($urandom_range(0, 1)),
                 int'($urandom_range(0, 15)));
        @(negedge clk);
        compare(exp_res, exp_ill, exp_tag);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule